// File: doc/BRIEF.md
# Clock Loss Detector and Safe-Clock Switch

This block checks that several external clocks are still running: the oscillator input, the crystal input, the receive recovery clock and the host bus clock. The check runs from a slow, free-running reference clock that does not depend on any of them. Each monitored clock has its own handshake. The reference domain flips a request bit. The monitored domain echoes that bit back through synchronisers. If the echo is late by a programmed number of reference periods, the clock counts as lost.

A loss sets a sticky per-clock failure bit and a sticky adapter-reset output. That output has the same effect as the hardware reset pin and holds the rest of the device in a low-power reset state. At the same time, a break-before-make clock switch moves the internal core clock off the oscillator and onto the reference clock.

Nothing clears automatically, even when the lost clocks return. Only a re-initialisation pulse from the host register path clears the state. That path stays usable while the adapter is held in reset. After the pulse, the core clock switches back to the oscillator.

Top module: `clk_fail_monitor`

## Requirements
- R1: While rst_ni is low, and on the first reference edge after it is released, fail_vec_o is all zeros and adapter_rst_o and slow_sel_o are 0. Asserting rst_ni also clears a failure that is already latched.
- R2: A monitored clock that keeps toggling is never flagged. This holds for any clock whose handshake round trip stays well below TIMEOUT reference periods.
- R3: If mon_clk_i[i] stops toggling, fail_vec_o[i] is set within TIMEOUT+8 reference periods of the stop. The bits of clocks that keep running stay 0.
- R4: adapter_rst_o is 1 exactly when at least one bit of fail_vec_o is 1.
- R5: A set fail_vec_o bit and adapter_rst_o stay set after the clock resumes, until reinit_i or rst_ni.
- R6: When reinit_i is 1 at a reference rising edge, fail_vec_o and adapter_rst_o are 0 after that edge. All timeout counters restart at that edge. A clock that has resumed stays clear. A clock that is still stopped is flagged again after a new timeout.
- R7: slow_sel_o rises only while adapter_rst_o is 1. While slow_sel_o is 1, core_clk_o carries ref_clk_i. While no failure is latched, core_clk_o carries mon_clk_i[FAST_IDX] (index 0 by default).
- R8: The enable of the fast source and the enable of the reference source of the core clock are never both active.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Slow free-running reference clock for detection and status |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mon_clk_i | input | NUM_CLK | Monitored clocks; bit i is monitored clock i |
| reinit_i | input | 1 | Host re-initialisation pulse, reference domain |
| fail_vec_o | output | NUM_CLK | Sticky lost-clock flags, bit i for mon_clk_i[i] |
| adapter_rst_o | output | 1 | Sticky reset request to the rest of the device |
| slow_sel_o | output | 1 | Core clock currently taken from the reference clock |
| core_clk_o | output | 1 | Glitch-free switched core clock |

## Verification
A loss is flagged no earlier than the timeout after the last completed handshake. For a running clock that handshake ends at most a few reference periods before the stop. The checks therefore sample fail_vec_o TIMEOUT+10 reference periods after a clock is halted, never at a single exact edge.

A host re-initialisation takes effect at the edge that samples it. The bench checks the cleared state one edge after the pulse, 1 ns past that edge. The clock switch needs two synchroniser stages and a falling edge on each side. Core clock edges are counted only in windows that open tens of reference periods after the switch was requested, and each count is compared with a tolerance of one edge.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
  localparam int unsigned CFM_DEF_TIMEOUT = 16;
  localparam int unsigned CFM_DEF_SYNC    = 2;

  function automatic int unsigned cnt_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/cfm_sync.sv
module cfm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/cfm_watch.sv
module cfm_watch #(
  parameter int unsigned TIMEOUT     = cfm_pkg::CFM_DEF_TIMEOUT,
  parameter int unsigned SYNC_STAGES = cfm_pkg::CFM_DEF_SYNC
) (
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic mon_clk_i,
  output logic timed_out_o
);
  localparam int unsigned CW = cfm_pkg::cnt_width(TIMEOUT);

  logic          req_q;
  logic          echo;
  logic          ack;
  logic [CW-1:0] wait_q;

  // request crosses into the monitored domain and returns as an echo
  cfm_sync #(.STAGES(SYNC_STAGES)) u_to_mon (
    .clk_i (mon_clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_q),
    .q_o   (echo)
  );

  cfm_sync #(.STAGES(SYNC_STAGES)) u_to_ref (
    .clk_i (ref_clk_i),
    .rst_ni(rst_ni),
    .d_i   (echo),
    .q_o   (ack)
  );

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      wait_q <= '0;
    end else if (restart_i) begin
      wait_q <= '0;
    end else if (ack == req_q) begin
      req_q  <= ~req_q;
      wait_q <= '0;
    end else if (wait_q != CW'(TIMEOUT)) begin
      wait_q <= wait_q + 1'b1;
    end
  end

  assign timed_out_o = (wait_q == CW'(TIMEOUT));
endmodule

// File: rtl/cfm_clk_switch.sv
module cfm_clk_switch #(
  parameter int unsigned SYNC_STAGES = cfm_pkg::CFM_DEF_SYNC
) (
  input  logic ref_clk_i,
  input  logic fast_clk_i,
  input  logic rst_ni,
  input  logic to_slow_i,
  output logic clk_o,
  output logic fast_en_o,
  output logic slow_en_o
);
  logic fast_en_q;
  logic slow_en_q;
  logic slow_en_f;
  logic fast_en_r;
  logic fast_rst_n;

  // fast side drops at once on a switch request, since its clock may be dead
  assign fast_rst_n = rst_ni & ~to_slow_i;

  cfm_sync #(.STAGES(SYNC_STAGES)) u_slow_to_fast (
    .clk_i (fast_clk_i),
    .rst_ni(rst_ni),
    .d_i   (slow_en_q),
    .q_o   (slow_en_f)
  );

  always_ff @(negedge fast_clk_i or negedge fast_rst_n) begin
    if (!fast_rst_n) fast_en_q <= 1'b0;
    else             fast_en_q <= ~slow_en_f;
  end

  cfm_sync #(.STAGES(SYNC_STAGES)) u_fast_to_ref (
    .clk_i (ref_clk_i),
    .rst_ni(rst_ni),
    .d_i   (fast_en_q),
    .q_o   (fast_en_r)
  );

  always_ff @(negedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) slow_en_q <= 1'b0;
    else         slow_en_q <= to_slow_i & ~fast_en_r;
  end

  assign clk_o     = (fast_clk_i & fast_en_q) | (ref_clk_i & slow_en_q);
  assign fast_en_o = fast_en_q;
  assign slow_en_o = slow_en_q;
endmodule

// File: rtl/clk_fail_monitor.sv
module clk_fail_monitor #(
  parameter int unsigned NUM_CLK     = 4,
  parameter int unsigned TIMEOUT     = cfm_pkg::CFM_DEF_TIMEOUT,
  parameter int unsigned SYNC_STAGES = cfm_pkg::CFM_DEF_SYNC,
  parameter int unsigned FAST_IDX    = 0
) (
  input  logic               ref_clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CLK-1:0] mon_clk_i,
  input  logic               reinit_i,
  output logic [NUM_CLK-1:0] fail_vec_o,
  output logic               adapter_rst_o,
  output logic               slow_sel_o,
  output logic               core_clk_o
);
  logic [NUM_CLK-1:0] timed_out;
  logic [NUM_CLK-1:0] fail_q;
  logic               adapter_q;
  logic               fast_en;
  logic               slow_en;

  for (genvar i = 0; i < NUM_CLK; i++) begin : g_watch
    cfm_watch #(
      .TIMEOUT    (TIMEOUT),
      .SYNC_STAGES(SYNC_STAGES)
    ) u_watch (
      .ref_clk_i  (ref_clk_i),
      .rst_ni     (rst_ni),
      .restart_i  (reinit_i),
      .mon_clk_i  (mon_clk_i[i]),
      .timed_out_o(timed_out[i])
    );
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q    <= '0;
      adapter_q <= 1'b0;
    end else if (reinit_i) begin
      fail_q    <= '0;
      adapter_q <= 1'b0;
    end else begin
      fail_q    <= fail_q | timed_out;
      adapter_q <= adapter_q | (|timed_out);
    end
  end

  cfm_clk_switch #(.SYNC_STAGES(SYNC_STAGES)) u_switch (
    .ref_clk_i (ref_clk_i),
    .fast_clk_i(mon_clk_i[FAST_IDX]),
    .rst_ni    (rst_ni),
    .to_slow_i (adapter_q),
    .clk_o     (core_clk_o),
    .fast_en_o (fast_en),
    .slow_en_o (slow_en)
  );

  assign fail_vec_o    = fail_q;
  assign adapter_rst_o = adapter_q;
  assign slow_sel_o    = slow_en;
endmodule

// File: rtl/cfm_checker.sv
module cfm_checker #(
  parameter int unsigned NUM_CLK = 4
) (
  input logic               ref_clk_i,
  input logic               rst_ni,
  input logic               reinit_i,
  input logic [NUM_CLK-1:0] fail_vec_o,
  input logic               adapter_rst_o,
  input logic               slow_sel_o,
  input logic               fast_en,
  input logic               slow_en
);
  assert_rst_tracks_fail_R4: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    adapter_rst_o == (fail_vec_o != '0));

  assert_sticky_fail_R5: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !reinit_i |=> ((fail_vec_o & $past(fail_vec_o)) == $past(fail_vec_o)));

  assert_sticky_rst_R5: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (adapter_rst_o && !reinit_i) |=> adapter_rst_o);

  assert_reinit_clears_R6: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    reinit_i |=> (fail_vec_o == '0 && !adapter_rst_o));

  assert_slow_only_in_rst_R7: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $rose(slow_sel_o) |-> adapter_rst_o);

  assert_break_make_R8: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !(fast_en && slow_en));
endmodule

bind clk_fail_monitor cfm_checker #(.NUM_CLK(NUM_CLK)) i_cfm_checker (
  .ref_clk_i    (ref_clk_i),
  .rst_ni       (rst_ni),
  .reinit_i     (reinit_i),
  .fail_vec_o   (fail_vec_o),
  .adapter_rst_o(adapter_rst_o),
  .slow_sel_o   (slow_sel_o),
  .fast_en      (fast_en),
  .slow_en      (slow_en)
);

// File: tb/test_clk_fail_monitor.sv
`timescale 1ns/1ps
module test_clk_fail_monitor;
  localparam int NCLK    = 4;
  localparam int TMO     = 16;
  localparam int SETTLE  = TMO + 10;
  localparam int WIN     = 25;

  logic            ref_clk = 1'b0;
  logic            rst_ni  = 1'b0;
  logic [NCLK-1:0] mclk    = '0;
  logic [NCLK-1:0] run     = '1;
  logic            reinit  = 1'b0;
  logic [NCLK-1:0] fail_vec;
  logic            adapter_rst;
  logic            slow_sel;
  logic            core_clk;

  int errors = 0;
  int checks = 0;
  int core_edges = 0;

  clk_fail_monitor #(.NUM_CLK(NCLK), .TIMEOUT(TMO)) i_clk_fail_monitor (
    .ref_clk_i    (ref_clk),
    .rst_ni       (rst_ni),
    .mon_clk_i    (mclk),
    .reinit_i     (reinit),
    .fail_vec_o   (fail_vec),
    .adapter_rst_o(adapter_rst),
    .slow_sel_o   (slow_sel),
    .core_clk_o   (core_clk)
  );

  always #2    ref_clk = ~ref_clk;
  always begin #1.25; if (run[0]) mclk[0] = ~mclk[0]; end
  always begin #1.5;  if (run[1]) mclk[1] = ~mclk[1]; end
  always begin #2.5;  if (run[2]) mclk[2] = ~mclk[2]; end
  always begin #3;    if (run[3]) mclk[3] = ~mclk[3]; end

  always @(posedge core_clk) core_edges++;

  function automatic logic exp_rst(logic [NCLK-1:0] m);
    return m != '0;
  endfunction

  // edges of the core clock expected over WIN reference periods
  function automatic int exp_edges(logic slow);
    return slow ? WIN : (WIN * 4 * 2) / 5;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ref(input int n);
    repeat (n) @(posedge ref_clk);
    #1;
  endtask

  task automatic pulse_reinit();
    @(posedge ref_clk); #1 reinit = 1'b1;
    @(posedge ref_clk); #1 reinit = 1'b0;
  endtask

  task automatic check_edges(input logic slow, input string req);
    int c0, d, e;
    c0 = core_edges;
    wait_ref(WIN);
    d = core_edges - c0;
    e = exp_edges(slow);
    chk(d >= e - 1 && d <= e + 1, req, d, e);
  endtask

  task automatic run_case(input logic [NCLK-1:0] mask);
    run = ~mask;
    wait_ref(SETTLE);
    chk(fail_vec == mask, "R3 lost clock flag", fail_vec, mask);
    chk(adapter_rst == exp_rst(mask), "R4 adapter reset", adapter_rst, exp_rst(mask));
    chk(slow_sel == exp_rst(mask), "R7 slow select", slow_sel, exp_rst(mask));
    if (mask != '0) check_edges(1'b1, "R7 core clock on reference");
    run = '1;
    wait_ref(30);
    chk(fail_vec == mask, "R5 flags held after resume", fail_vec, mask);
    chk(adapter_rst == exp_rst(mask), "R5 reset held after resume", adapter_rst, exp_rst(mask));
    pulse_reinit();
    chk(fail_vec == '0 && !adapter_rst, "R6 cleared by reinit", {adapter_rst, fail_vec}, 0);
    wait_ref(30);
    chk(fail_vec == '0, "R6 resumed clocks stay clear", fail_vec, 0);
    chk(slow_sel == 1'b0, "R7 back on fast clock", slow_sel, 0);
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    wait_ref(5);
    chk(fail_vec == '0 && !adapter_rst && !slow_sel, "R1 reset state",
        {slow_sel, adapter_rst, fail_vec}, 0);
    @(negedge ref_clk); rst_ni = 1'b1;
    wait_ref(1);
    chk(fail_vec == '0 && !adapter_rst && !slow_sel, "R1 first edge after reset",
        {slow_sel, adapter_rst, fail_vec}, 0);

    wait_ref(50);
    chk(fail_vec == '0, "R2 running clocks not flagged", fail_vec, 0);
    chk(!slow_sel, "R7 fast source after reset", slow_sel, 0);
    check_edges(1'b0, "R7 core clock on oscillator");

    run_case(4'b0001);
    run_case(4'b1000);
    run_case(4'b0110);
    for (int k = 0; k < 6; k++) begin
      logic [NCLK-1:0] m;
      m = NCLK'($urandom % 16);
      run_case(m);
    end

    for (int k = 0; k < 4; k++) begin
      wait_ref(40 + int'($urandom % 60));
      chk(fail_vec == '0, "R2 long run not flagged", fail_vec, 0);
    end

    // reinit while a clock is still stopped
    run = 4'b1011;
    wait_ref(SETTLE);
    chk(fail_vec == 4'b0100, "R3 single lost clock", fail_vec, 4'b0100);
    pulse_reinit();
    chk(fail_vec == '0, "R6 reinit clears dead clock", fail_vec, 0);
    wait_ref(SETTLE);
    chk(fail_vec == 4'b0100, "R6 dead clock flagged again", fail_vec, 4'b0100);
    run = '1;
    pulse_reinit();
    wait_ref(30);
    chk(fail_vec == '0 && !slow_sel, "R6 recovered after second reinit",
        {slow_sel, fail_vec}, 0);

    // hardware reset clears a latched failure
    run = 4'b1101;
    wait_ref(SETTLE);
    chk(fail_vec == 4'b0010, "R3 clock 1 lost", fail_vec, 4'b0010);
    @(negedge ref_clk); rst_ni = 1'b0;
    #1;
    chk(fail_vec == '0 && !adapter_rst, "R1 reset clears failure", {adapter_rst, fail_vec}, 0);
    run = '1;
    wait_ref(3);
    @(negedge ref_clk); rst_ni = 1'b1;
    wait_ref(40);
    chk(fail_vec == '0 && !adapter_rst, "R1 clean after reset", {adapter_rst, fail_vec}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule